// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a single-clock synchronous SRAM. Read and write cycles may follow each other on every clock with no idle cycle between them. Address, control, chip-select and byte-enable inputs are sampled on the rising clock edge. A cycle is loaded when `load_n_i` is low. A loaded cycle fixes its type as read, write or deselect. Cycles with `load_n_i` high continue a four-beat burst and keep the loaded type.

Write data arrives one enabled clock after its address. It is held in a one-entry pending buffer, and the buffer is committed to the array at the next enabled edge. A read of the address held in the buffer sees the pending bytes, merged lane by lane over the array contents. Read data follows flow-through timing: it appears in the cycle after the edge that registered the read address.

Three things gate the outputs. The output enable acts asynchronously. The sleep input blocks drive and makes new loads deselects. A low clock enable freezes every piece of internal state, the array included.

Top module: `zero_turn_sram`

## Requirements
- R1: After the asynchronous reset `rst_ni`, and before any cycle is loaded, `drive_o` is 0 and `data_o` is 0.
- R2: A read loaded at an enabled edge drives `drive_o`=1 and the stored word on `data_o` during the following cycle, when `out_en_ni` is low and `sleep_i` is low.
- R3: The data for a write is taken from `wdata_i` at the next enabled edge after its address edge. Only the lanes whose `lane_we_ni` bit was low at the address edge are written. Lane mapping is: bit 0 to data bits 8:0, bit 1 to bits 17:9, bit 2 to bits 26:18, bit 3 to bits 35:27.
- R4: Writes and reads may alternate on consecutive enabled edges, and every read returns the correct data with no inserted wait cycle.
- R5: A read of an address whose write data was captured but not yet committed returns the pending bytes for the enabled lanes and the array bytes for the other lanes.
- R6: A cycle is selected only when `sel_n_i`=0, `sel_i`=1 and `sel2_n_i`=0 at a load. Any other combination is a deselect, which neither drives the outputs nor writes the array.
- R7: When `load_n_i` is high, the address advances within an aligned block of four. With `burst_lin_i`=1 the low two bits are base+n mod 4; with 0 they are base XOR n. The type is inherited, and `rd_wr_i` and the selects are ignored.
- R8: When `clk_en_i` is low, no state changes at that edge: the output word, the burst position and the pending write are all kept.
- R9: `out_en_ni` high forces `drive_o`=0 and `data_o`=0 within the same cycle, without waiting for a clock edge.
- R10: `sleep_i` high forces `drive_o`=0 at once, and any cycle loaded while it is high is a deselect.
- R11: A write cycle never drives the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable; low freezes all state |
| addr_i | input | ADDR_W | Word address |
| load_n_i | input | 1 | Low loads a new cycle; high continues the burst |
| rd_wr_i | input | 1 | 1 read, 0 write (at load) |
| sel_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| sel2_n_i | input | 1 | Second chip select, active low |
| lane_we_ni | input | LANES | Per-lane write enables, active low |
| burst_lin_i | input | 1 | 1 linear burst order, 0 interleaved |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request |
| wdata_i | input | LANES*LANE_W | Write data, one enabled cycle after the address |
| data_o | output | LANES*LANE_W | Read data, zero when not driven |
| drive_o | output | 1 | High when `data_o` is driven |

## Verification
The sharpest collision is a read whose address matches a write whose data is captured on the same edge that registers the read. The array still holds the old word, so the output must come from the pending buffer. The bench provokes this with write-then-read pairs to one address: a full-word write, a partial-lane write over a known word, and a burst whose last write beat lands at the start of an interleaved read burst. It judges each case by comparing every 9-bit lane against the value the requirements predict. A second collision is a frozen edge that falls between a write address and its data. Here the bench checks that the data taken is the value present at the next enabled edge.

// File: rtl/zts_pkg.sv
package zts_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/zts_addr_gen.sv
module zts_addr_gen
  import zts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              sel_ok_i,
  input  logic              rd_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cyc_kind_e         kind_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  cyc_kind_e         kind_q;
  logic [1:0]        low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      kind_q <= CYC_IDLE;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        kind_q <= sel_ok_i ? (rd_i ? CYC_READ : CYC_WRITE) : CYC_IDLE;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  always_comb low = lin_i ? (base_q[1:0] + cnt_q) : (base_q[1:0] ^ cnt_q);

  assign addr_o = {base_q[ADDR_W-1:2], low};
  assign kind_o = kind_q;

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(base_q) && $stable(cnt_q) && $stable(kind_q)));
  p_load_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> (cnt_q == 2'd0));
  p_burst_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));
  p_burst_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> $stable(kind_q));
endmodule

// File: rtl/zts_write_buf.sv
module zts_write_buf #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [LANES-1:0]  cap_be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DW-1:0]     arr_data_i,
  output logic              cm_v_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [LANES-1:0]  cm_be_o,
  output logic [DW-1:0]     cm_data_o,
  output logic [DW-1:0]     rd_data_o
);
  logic              pv_q;
  logic [ADDR_W-1:0] pa_q;
  logic [LANES-1:0]  pbe_q;
  logic [DW-1:0]     pd_q;

  // one-entry pending buffer: refilled or emptied on every enabled edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q  <= 1'b0;
      pa_q  <= '0;
      pbe_q <= '0;
      pd_q  <= '0;
    end else if (en_i) begin
      pv_q <= cap_i;
      if (cap_i) begin
        pa_q  <= cap_addr_i;
        pbe_q <= cap_be_i;
        pd_q  <= wdata_i;
      end
    end
  end

  assign cm_v_o    = pv_q;
  assign cm_addr_o = pa_q;
  assign cm_be_o   = pbe_q;
  assign cm_data_o = pd_q;

  logic hit;
  assign hit = pv_q && (pa_q == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_byp
    assign rd_data_o[l*LANE_W +: LANE_W] = (hit && pbe_q[l]) ? pd_q[l*LANE_W +: LANE_W]
                                                            : arr_data_i[l*LANE_W +: LANE_W];
  end

  p_pend_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !cap_i) |=> !pv_q);
  p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(pv_q) && $stable(pd_q) && $stable(pa_q)));
endmodule

// File: rtl/zts_array.sv
module zts_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/zero_turn_sram.sv
module zero_turn_sram
  import zts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_n_i,
  input  logic              rd_wr_i,
  input  logic              sel_n_i,
  input  logic              sel_i,
  input  logic              sel2_n_i,
  input  logic [LANES-1:0]  lane_we_ni,
  input  logic              burst_lin_i,
  input  logic              out_en_ni,
  input  logic              sleep_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     data_o,
  output logic              drive_o
);
  cyc_kind_e         kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  be_q;
  logic              sel_ok;
  logic              cm_v;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_be;
  logic [DW-1:0]     cm_data;
  logic [DW-1:0]     arr_data;
  logic [DW-1:0]     rd_data;

  assign sel_ok = !sel_n_i && sel_i && !sel2_n_i && !sleep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       be_q <= '0;
    else if (clk_en_i) be_q <= ~lane_we_ni;
  end

  zts_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (clk_en_i),
    .load_i   (!load_n_i),
    .sel_ok_i (sel_ok),
    .rd_i     (rd_wr_i),
    .lin_i    (burst_lin_i),
    .addr_i   (addr_i),
    .kind_o   (kind),
    .addr_o   (cur_addr)
  );

  zts_write_buf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (clk_en_i),
    .cap_i      (kind == CYC_WRITE),
    .cap_addr_i (cur_addr),
    .cap_be_i   (be_q),
    .wdata_i    (wdata_i),
    .rd_addr_i  (cur_addr),
    .arr_data_i (arr_data),
    .cm_v_o     (cm_v),
    .cm_addr_o  (cm_addr),
    .cm_be_o    (cm_be),
    .cm_data_o  (cm_data),
    .rd_data_o  (rd_data)
  );

  zts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i   (clk_i),
    .we_i    (clk_en_i && cm_v),
    .waddr_i (cm_addr),
    .be_i    (cm_be),
    .wdata_i (cm_data),
    .raddr_i (cur_addr),
    .rdata_o (arr_data)
  );

  assign drive_o = (kind == CYC_READ) && !out_en_ni && !sleep_i;
  assign data_o  = drive_o ? rd_data : '0;

  p_write_no_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && !load_n_i && !rd_wr_i && !sel_n_i && sel_i && !sel2_n_i) |=> !drive_o);
  p_deselect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && !load_n_i && (sel_n_i || !sel_i || sel2_n_i)) |=> !drive_o);
  p_sleep_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && !load_n_i && sleep_i) |=> !drive_o);
endmodule

// File: tb/tb_zero_turn_sram.sv
module tb_zero_turn_sram;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          clk_en_i = 1;
  logic [AW-1:0] addr_i = '0;
  logic          load_n_i = 0;
  logic          rd_wr_i = 1;
  logic          sel_n_i = 1;
  logic          sel_i = 1;
  logic          sel2_n_i = 0;
  logic [3:0]    lane_we_ni = 4'hF;
  logic          burst_lin_i = 1;
  logic          out_en_ni = 0;
  logic          sleep_i = 0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] data_o;
  logic          drive_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  zero_turn_sram dut (.*);

  localparam logic [DW-1:0] D1   = {9'h101, 9'h0A2, 9'h1C3, 9'h034};
  localparam logic [DW-1:0] D10  = {9'h110, 9'h011, 9'h112, 9'h013};
  localparam logic [DW-1:0] D11  = {9'h0F1, 9'h1E2, 9'h0D3, 9'h1C4};
  localparam logic [DW-1:0] D20  = {9'h120, 9'h021, 9'h122, 9'h023};
  localparam logic [DW-1:0] D30  = {9'h030, 9'h131, 9'h032, 9'h133};
  localparam logic [DW-1:0] D40  = {9'h140, 9'h041, 9'h142, 9'h043};
  localparam logic [DW-1:0] GARB = {4{9'h1FF}};
  localparam logic [DW-1:0] P    = {9'h111, 9'h122, 9'h133, 9'h144};
  localparam logic [DW-1:0] Q    = {9'h0AA, 9'h0BB, 9'h0CC, 9'h0DD};

  task automatic chk_rd(input string tag, input logic [DW-1:0] exp);
    n_run++;
    if (drive_o !== 1'b1 || data_o !== exp) begin
      n_fail++;
      $display("FAIL %s: drive=%b data=%h expected drive=1 data=%h", tag, drive_o, data_o, exp);
    end
  endtask

  task automatic chk_off(input string tag);
    n_run++;
    if (drive_o !== 1'b0 || data_o !== '0) begin
      n_fail++;
      $display("FAIL %s: drive=%b data=%h expected drive=0 data=0", tag, drive_o, data_o);
    end
  endtask

  task automatic cyc(input logic ld, input logic rd, input logic [AW-1:0] a,
                     input logic [3:0] ben, input logic [DW-1:0] wd);
    load_n_i = !ld; rd_wr_i = rd; addr_i = a; lane_we_ni = ben; wdata_i = wd;
    @(posedge clk_i); #5;
  endtask

  task automatic sel_good();
    sel_n_i = 0; sel_i = 1; sel2_n_i = 0;
  endtask

  task automatic t_reset();
    #5 chk_off("R1 in reset");
    rst_ni = 1;
    #3 chk_off("R1 after release");
    sel_good();
  endtask

  task automatic t_write_read();
    cyc(1, 0, 6'd5, 4'h0, '0);
    chk_off("R11 write cycle");
    cyc(1, 1, 6'd5, 4'h0, D1);
    chk_rd("R5 bypass full word", D1);
    sel_n_i = 1;
    cyc(1, 1, 6'd0, 4'hF, '0);
    chk_off("R6 deselected read");
    sel_good();
    cyc(1, 1, 6'd5, 4'hF, '0);
    chk_rd("R2 array read", D1);
  endtask

  task automatic t_bytes();
    cyc(1, 0, 6'd7, 4'h0, '0);
    cyc(1, 0, 6'd7, 4'b1010, P);
    cyc(1, 1, 6'd7, 4'hF, Q);
    chk_rd("R3 R5 lane merge bypass", {P[35:27], Q[26:18], P[17:9], Q[8:0]});
    cyc(1, 1, 6'd7, 4'hF, '0);
    chk_rd("R3 lane merge array", {P[35:27], Q[26:18], P[17:9], Q[8:0]});
  endtask

  task automatic t_b2b();
    cyc(1, 0, 6'd10, 4'h0, '0);
    cyc(1, 1, 6'd5, 4'hF, D10);
    chk_rd("R4 read after write", D1);
    cyc(1, 0, 6'd11, 4'h0, '0);
    chk_off("R11 write between reads");
    cyc(1, 1, 6'd10, 4'hF, D11);
    chk_rd("R4 read 10", D10);
    cyc(1, 1, 6'd11, 4'hF, '0);
    chk_rd("R4 read 11", D11);
  endtask

  task automatic t_select();
    cyc(1, 0, 6'd20, 4'h0, '0);
    cyc(1, 1, 6'd0, 4'hF, D20);
    for (int k = 0; k < 3; k++) begin
      sel_good();
      if (k == 0) sel_n_i = 1;
      if (k == 1) sel_i = 0;
      if (k == 2) sel2_n_i = 1;
      cyc(1, 1, 6'd20, 4'hF, '0);
      chk_off("R6 bad select read");
      cyc(1, 0, 6'd20, 4'h0, '0);
      sel_good();
      cyc(1, 1, 6'd20, 4'hF, GARB);
      chk_rd("R6 bad select write ignored", D20);
    end
  endtask

  task automatic t_burst();
    logic [DW-1:0] d [4];
    for (int i = 0; i < 4; i++) d[i] = {4{9'(9'h050 + i)}};
    burst_lin_i = 1;
    cyc(1, 0, 6'h22, 4'h0, '0);
    sel_n_i = 1;
    cyc(0, 1, 6'h00, 4'h0, d[0]);
    chk_off("R7 write burst inherits type");
    cyc(0, 1, 6'h00, 4'h0, d[1]);
    cyc(0, 1, 6'h00, 4'h0, d[2]);
    sel_good();
    cyc(1, 1, 6'h21, 4'hF, d[3]);
    chk_rd("R7 linear wrap beat 3 bypass", d[3]);
    burst_lin_i = 0;
    #1;
    sel_n_i = 1;
    cyc(0, 0, 6'h00, 4'hF, '0);
    chk_rd("R7 interleaved beat 1", d[2]);
    cyc(0, 0, 6'h00, 4'hF, '0);
    chk_rd("R7 interleaved beat 2", d[1]);
    cyc(0, 0, 6'h00, 4'hF, '0);
    chk_rd("R7 interleaved beat 3", d[0]);
    sel_good();
    burst_lin_i = 1;
  endtask

  task automatic t_cen();
    cyc(1, 1, 6'd10, 4'hF, '0);
    chk_rd("R8 baseline", D10);
    clk_en_i = 0;
    cyc(1, 1, 6'd5, 4'hF, '0);
    chk_rd("R8 frozen output", D10);
    clk_en_i = 1;
    cyc(1, 0, 6'd30, 4'h0, '0);
    clk_en_i = 0;
    cyc(1, 1, 6'd5, 4'hF, GARB);
    clk_en_i = 1;
    cyc(1, 1, 6'd30, 4'hF, D30);
    chk_rd("R8 write data after frozen edge", D30);
  endtask

  task automatic t_oe();
    cyc(1, 1, 6'd5, 4'hF, '0);
    out_en_ni = 1;
    #1 chk_off("R9 async disable");
    out_en_ni = 0;
    #1 chk_rd("R9 async enable", D1);
  endtask

  task automatic t_sleep();
    cyc(1, 0, 6'd40, 4'h0, '0);
    cyc(1, 1, 6'd5, 4'hF, D40);
    sleep_i = 1;
    #1 chk_off("R10 sleep gates output");
    cyc(1, 0, 6'd40, 4'h0, '0);
    cyc(1, 1, 6'd40, 4'hF, GARB);
    sleep_i = 0;
    #1 chk_off("R10 load in sleep is deselect");
    cyc(1, 1, 6'd40, 4'hF, '0);
    chk_rd("R10 write in sleep ignored", D40);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_bytes();
    t_b2b();
    t_select();
    t_burst();
    t_cen();
    t_oe();
    t_sleep();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule